// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Pulse

This block turns one fast source clock into four divided output banks, called A, B, C and D. Each bank has its own integer divider. A 3-bit static select per bank picks the ratio. Every bank drives a true output and its complement.

A coincidence detector watches banks A and C. It raises a pulse one source cycle wide on every source cycle in which both banks rise together. This is most useful when the two ratios are not integer multiples of each other: for example, with ratios 4 and 6 the pulse repeats every 12 source cycles.

A copy-select input changes the use of the last two outputs. When it is high, bank D reproduces bank C and the coincidence pulse is held low. When it is low, bank D runs from its own divider and the pulse works normally. A synchronous active-high reset clears every divider. All banks leave reset on the same edge, so their first rising edges are aligned.

Top module: `bank_clock_divider`

## Requirements
- R1: Each bank's divide ratio N comes from its 3-bit select: 0→2, 1→4, 2→6, 3→8, 4→12, 5, 6 and 7→16. The true output is high for N/2 source cycles and low for N/2, and its period is N.
- R2: The four banks divide independently. Each bank's ratio depends only on its own select.
- R3: On every clock edge with `rst` high, all true outputs go low, all complement outputs go high and `sync_pulse` goes low.
- R4: On the first clock edge with `rst` low after a reset, every bank's true output rises. Bank rises then follow at t = 0, N, 2N, and so on, where t counts edges from that first edge.
- R5: The ratio selects are captured only while `rst` is high. Changing them while the block runs has no effect on any output until the next reset.
- R6: With `copy_sel` low, `sync_pulse` is high exactly in the cycles in which both `out_a` and `out_c` have just risen. Over T cycles after reset it therefore pulses ceil(T/L) times, where L is the least common multiple of the A and C ratios. It is never high on two consecutive cycles.
- R7: While `copy_sel` is high, `out_d` equals `out_c` and `sync_pulse` is held low. While `copy_sel` is low, `out_d` follows bank D's own divider. The selection takes effect in the same cycle.
- R8: Each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high master reset; ratio selects are captured while it is high |
| sel_a | input | 3 | Bank A ratio select |
| sel_b | input | 3 | Bank B ratio select |
| sel_c | input | 3 | Bank C ratio select |
| sel_d | input | 3 | Bank D ratio select |
| copy_sel | input | 1 | High: bank D copies bank C and the pulse is held low |
| out_a | output | 1 | Bank A true output |
| out_a_n | output | 1 | Bank A complement output |
| out_b | output | 1 | Bank B true output |
| out_b_n | output | 1 | Bank B complement output |
| out_c | output | 1 | Bank C true output |
| out_c_n | output | 1 | Bank C complement output |
| out_d | output | 1 | Bank D true output (or copy of C) |
| out_d_n | output | 1 | Bank D complement output |
| sync_pulse | output | 1 | One-cycle A/C coincidence pulse |

## Verification
Bank outputs and `sync_pulse` each pass through exactly one register, so every result of an edge is due on that same edge. Each result is sampled at the following falling edge and compared with a behavioural model that counts edges since reset release. `copy_sel` acts through combinational paths only, so its effect is checked in the same cycle it is driven. Ratio select changes during a run take effect only after the next reset edge. The model therefore latches them only while reset is applied, and the expected output stays on the old ratio until the block is reset again.

// File: rtl/bank_clock_divider.sv
module bank_clock_divider #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic [2:0] sel_c,
  input  logic [2:0] sel_d,
  input  logic       copy_sel,
  output logic       out_a,
  output logic       out_a_n,
  output logic       out_b,
  output logic       out_b_n,
  output logic       out_c,
  output logic       out_c_n,
  output logic       out_d,
  output logic       out_d_n,
  output logic       sync_pulse
);

  localparam int NB = 4;

  function automatic logic [CNT_W-1:0] half_of(input logic [2:0] s);
    case (s)
      3'd0:    return CNT_W'(1);
      3'd1:    return CNT_W'(2);
      3'd2:    return CNT_W'(3);
      3'd3:    return CNT_W'(4);
      3'd4:    return CNT_W'(6);
      default: return CNT_W'(8);
    endcase
  endfunction

  logic [2:0] sel [NB];
  logic [NB-1:0] q, rise;
  logic sync_r;

  assign sel[0] = sel_a;
  assign sel[1] = sel_b;
  assign sel[2] = sel_c;
  assign sel[3] = sel_d;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic [CNT_W-1:0] half_r, cnt_r;
    logic q_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        half_r <= half_of(sel[i]);
        cnt_r  <= '0;
        q_r    <= 1'b0;
      end else begin
        if (cnt_r == '0) q_r <= ~q_r;
        cnt_r <= (cnt_r == half_r - 1'b1) ? '0 : cnt_r + 1'b1;
      end
    end
    assign q[i]    = q_r;
    assign rise[i] = (cnt_r == '0) && !q_r;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_r <= 1'b0;
    else     sync_r <= rise[0] & rise[2];
  end

  assign out_a      = q[0];
  assign out_b      = q[1];
  assign out_c      = q[2];
  assign out_d      = copy_sel ? q[2] : q[3];
  assign out_a_n    = ~out_a;
  assign out_b_n    = ~out_b;
  assign out_c_n    = ~out_c;
  assign out_d_n    = ~out_d;
  assign sync_pulse = sync_r & ~copy_sel;

endmodule

// File: rtl/bank_clock_divider_chk.sv
module bank_clock_divider_chk (
  input logic clk,
  input logic rst,
  input logic copy_sel,
  input logic out_a,
  input logic out_b,
  input logic out_c,
  input logic out_d,
  input logic out_d_n,
  input logic sync_pulse
);

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b && !out_c && !out_d && !sync_pulse));

  // R6
  sync_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> (out_a && out_c && !$past(out_a) && !$past(out_c)));

  // R6
  rise_gives_sync_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_a) && $rose(out_c) && !copy_sel) |-> sync_pulse);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  // R7
  copy_follow_chk: assert property (@(posedge clk) disable iff (rst)
    copy_sel |-> (out_d == out_c && !sync_pulse));

  // R8
  d_compl_chk: assert property (@(posedge clk) disable iff (rst)
    out_d_n == !out_d);

endmodule

bind bank_clock_divider bank_clock_divider_chk u_chk (
  .clk(clk), .rst(rst), .copy_sel(copy_sel),
  .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
  .out_d_n(out_d_n), .sync_pulse(sync_pulse)
);

// File: tb/tb_bank_clock_divider.sv
`timescale 1ns/1ps
module tb_bank_clock_divider;
  logic clk = 0, rst = 1, copy_sel = 0;
  logic [2:0] sel_a = 0, sel_b = 0, sel_c = 0, sel_d = 0;
  logic out_a, out_a_n, out_b, out_b_n, out_c, out_c_n, out_d, out_d_n, sync_pulse;

  bank_clock_divider dut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, pulses = 0;
  int na = 2, nb = 2, nc = 2, nd = 2, t = 0;
  bit run = 0, armed = 0, finished = 0;

  function automatic int ratio(input logic [2:0] s);
    case (s)
      0: return 2;  1: return 4;  2: return 6;
      3: return 8;  4: return 12; default: return 16;
    endcase
  endfunction

  function automatic int lcm(input int x, input int y);
    int g = x, h = y;
    while (h != 0) begin int r = g % h; g = h; h = r; end
    return x / g * y;
  endfunction

  function automatic logic bank(input int n);
    return run && ((t % n) < n / 2);
  endfunction

  task automatic chk(input string tag, input logic act, input logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0d run=%0d", tag, act, expv, t, run);
    end
  endtask

  // behavioural model: latch ratios in reset, count edges after release
  always @(posedge clk) begin
    if (rst) begin
      run <= 0; t <= 0;
      na <= ratio(sel_a); nb <= ratio(sel_b);
      nc <= ratio(sel_c); nd <= ratio(sel_d);
    end else if (!run) begin
      run <= 1; t <= 0;
    end else t <= t + 1;
  end

  always @(negedge clk) if (armed) begin
    logic ea, ec, ed, es;
    ea = bank(na); ec = bank(nc);
    ed = copy_sel ? ec : bank(nd);
    es = run && !copy_sel && (t % na == 0) && (t % nc == 0);
    if (!run) chk("R3 reset outputs", out_a | out_b | out_c | out_d | sync_pulse, 1'b0);
    chk("R1 R4 R5 out_a", out_a, ea);
    chk("R2 R5 out_b", out_b, bank(nb));
    chk("R2 out_c", out_c, ec);
    chk("R7 out_d", out_d, ed);
    chk("R6 R7 sync_pulse", sync_pulse, es);
    chk("R8 complements", {out_a_n, out_b_n, out_c_n, out_d_n} == ~{out_a, out_b, out_c, out_d}, 1'b1);
    if (run && sync_pulse) pulses++;
  end

  task automatic start(input logic [2:0] a, b, c, d, input logic cp);
    @(posedge clk); #1;
    rst = 1; sel_a = a; sel_b = b; sel_c = c; sel_d = d; copy_sel = cp;
    repeat (3) @(posedge clk);
    #1 rst = 0; pulses = 0;
  endtask

  task automatic run_case(input logic [2:0] a, b, c, d, input logic cp, input int cyc);
    int l;
    start(a, b, c, d, cp);
    repeat (cyc) @(posedge clk);
    @(negedge clk); #1;
    l = lcm(ratio(a), ratio(c));
    chk("R6 pulse count", pulses == (cp ? 0 : (cyc + l - 1) / l), 1'b1);
  endtask

  initial begin
    @(posedge clk); #1 armed = 1;
    run_case(3'd1, 3'd3, 3'd2, 3'd5, 1'b0, 120);   // 4 vs 6 -> every 12
    run_case(3'd2, 3'd4, 3'd5, 3'd0, 1'b0, 200);   // 6 vs 16 -> every 48
    run_case(3'd0, 3'd1, 3'd0, 3'd2, 1'b0, 40);    // 2 vs 2 -> every 2
    run_case(3'd3, 3'd6, 3'd4, 3'd7, 1'b0, 100);   // 8 vs 12, codes 6/7 -> 16
    run_case(3'd3, 3'd0, 3'd4, 3'd1, 1'b1, 100);   // R7 copy mode
    // R7 toggle copy_sel mid-run
    start(3'd1, 3'd2, 3'd3, 3'd0, 1'b0);
    repeat (30) @(posedge clk); #1 copy_sel = 1;
    repeat (30) @(posedge clk); #1 copy_sel = 0;
    repeat (30) @(posedge clk);
    // R5 select changes while running are ignored until reset
    start(3'd1, 3'd1, 3'd2, 3'd3, 1'b0);
    repeat (20) @(posedge clk); #1;
    sel_a = 3'd5; sel_b = 3'd0; sel_c = 3'd4; sel_d = 3'd2;
    repeat (60) @(posedge clk);
    start(3'd5, 3'd0, 3'd4, 3'd2, 1'b0);
    repeat (60) @(posedge clk);
    @(negedge clk); #1;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule